// File: doc/BRIEF.md
# Instruction Stream Buffer Prefetcher

This unit sits between a direct-mapped instruction cache and the next memory level. It serves line misses from the cache and adds sequential prefetching of instruction lines. A one-entry stream buffer holds the line that follows the last demanded one. The cache never receives a line speculatively: a buffered line reaches the cache only when the cache misses on it.

When the cache reports a miss on line address A and the buffer does not hold A, the unit reads A from the next level and writes it into the cache. It then reads A+1 into the stream buffer. When a later miss matches the buffered line, that line goes to the cache on the next cycle with no memory access, and a read of the line after it starts at once. The next-level port carries at most one read at a time. A demand miss always takes precedence over prefetch traffic.

Top module: `isb_prefetch`

## Requirements
- R1: While and after reset, `fill_valid` and `mem_req_valid` are low, `miss_ready` is high and the stream buffer is empty.
- R2: A miss on line address A that does not match the stream buffer issues a next-level read with `mem_req_addr` = A. The cycle after its response, the unit presents `fill_valid` with `fill_addr` = A and `fill_data` equal to the response data.
- R3: After a demand fill of A, the unit reads line (A+1) modulo 2^ADDR_W from the next level and places the response in the stream buffer. Address 2^ADDR_W-1 wraps to 0.
- R4: A miss on A while the stream buffer holds a valid line A is filled in the cycle after the miss is accepted. The fill carries the buffered data and no next-level read is made for A.
- R5: A stream-buffer hit on A empties the buffer and starts a next-level read of (A+1) modulo 2^ADDR_W into it.
- R6: A miss that does not match the stream buffer discards the buffered line. A later miss on the discarded address goes to the next level.
- R7: A prefetch read that the next level has not yet accepted when a non-matching miss is accepted is cancelled. The next request issued is the demand address.
- R8: A prefetch read already accepted by the next level when a non-matching miss is accepted is not buffered when its response returns. The demand read is issued after that response.
- R9: `mem_req_valid` is never high while an accepted read is still waiting for its response.
- R10: `miss_ready` is low from the cycle after a non-matching miss is accepted until the cycle after its demand response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Cache reports a line miss |
| miss_addr | input | ADDR_W | Line address of the miss |
| miss_ready | output | 1 | Unit accepts a miss this cycle |
| fill_valid | output | 1 | Line write into the cache this cycle |
| fill_addr | output | ADDR_W | Line address of the fill |
| fill_data | output | LINE_W | Line contents of the fill |
| mem_req_valid | output | 1 | Read request to the next level |
| mem_req_addr | output | ADDR_W | Line address of the read |
| mem_req_ready | input | 1 | Next level accepts the read |
| mem_resp_valid | input | 1 | Read data returns |
| mem_resp_data | input | LINE_W | Returned line |

## Verification
The bench builds the unit with ADDR_W = 12 and LINE_W = 64. The small address space lets a miss on the top line 0xFFF exercise the prefetch wrap to line 0. The bench varies the next-level latency from one to six cycles and can hold the request-ready input low. Long latency keeps a prefetch outstanding while a new miss arrives. A held ready leaves a prefetch waiting unaccepted when a demand pre-empts it.

// File: rtl/isb_pkg.sv
// Shared types for the instruction stream buffer prefetcher.
// Assumes nothing beyond SystemVerilog 2017 enums.
package isb_pkg;
    // Demand-side sequencing of the controller.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DEM_REQ  = 2'd1,
        ST_DEM_WAIT = 2'd2
    } isb_state_e;
endpackage

// File: rtl/isb_line_buf.sv
// One-entry stream buffer: line address, line data and a valid flag.
// Compares its address against the lookup address every cycle.
// Assumes a clear and a write never need to both take effect; clear wins.
module isb_line_buf #(
    parameter int ADDR_W = 12,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              clear,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic              valid_o,
    output logic [LINE_W-1:0] data_o
);
    logic              vld_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LINE_W-1:0] data_q;

    // Holds the buffered line; a clear discards it ahead of any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (clear) begin
            vld_q <= 1'b0;
        end else if (wr_en) begin
            vld_q  <= 1'b1;
            addr_q <= wr_addr;
            data_q <= wr_data;
        end
    end

    // Tag match for the current miss address.
    always_comb begin
        hit = vld_q && (addr_q == look_addr);
    end

    assign valid_o = vld_q;
    assign data_o  = data_q;
endmodule

// File: rtl/isb_ctrl.sv
// Miss sequencing and next-level read engine for the stream buffer.
// Serves matching misses from the buffer, sends other misses to memory,
// keeps one read outstanding at most, and gives demands priority over
// prefetches. Assumes the next level answers every accepted read once.
module isb_ctrl
    import isb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_ready,
    input  logic              sb_hit,
    input  logic [LINE_W-1:0] sb_data,
    output logic              sb_wr_en,
    output logic [ADDR_W-1:0] sb_wr_addr,
    output logic [LINE_W-1:0] sb_wr_data,
    output logic              sb_clear,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              req_ready,
    input  logic              resp_valid,
    input  logic [LINE_W-1:0] resp_data,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [LINE_W-1:0] fill_data
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    isb_state_e        state_q;
    logic              pf_pend_q;
    logic [ADDR_W-1:0] pf_addr_q;
    logic [ADDR_W-1:0] dem_addr_q;
    logic              busy_q;
    logic              miss_fire;
    logic              req_fire;

    // Handshakes, read arbitration and stream-buffer write/clear strobes.
    always_comb begin
        miss_ready = (state_q == ST_IDLE);
        miss_fire  = miss_valid && miss_ready;
        req_valid  = !busy_q &&
                     ((state_q == ST_DEM_REQ) || ((state_q == ST_IDLE) && pf_pend_q));
        req_addr   = (state_q == ST_DEM_REQ) ? dem_addr_q : pf_addr_q;
        req_fire   = req_valid && req_ready;
        sb_clear   = miss_fire;
        sb_wr_en   = resp_valid && busy_q && (state_q == ST_IDLE);
        sb_wr_addr = pf_addr_q;
        sb_wr_data = resp_data;
    end

    // Sequencing state, outstanding-read tracking and the registered fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pf_pend_q  <= 1'b0;
            pf_addr_q  <= '0;
            dem_addr_q <= '0;
            busy_q     <= 1'b0;
            fill_valid <= 1'b0;
            fill_addr  <= '0;
            fill_data  <= '0;
        end else begin
            fill_valid <= 1'b0;
            if (req_fire) begin
                busy_q <= 1'b1;
            end else if (resp_valid) begin
                busy_q <= 1'b0;
            end
            if (req_fire && (state_q == ST_IDLE)) begin
                pf_pend_q <= 1'b0;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (miss_fire && sb_hit) begin
                        fill_valid <= 1'b1;
                        fill_addr  <= miss_addr;
                        fill_data  <= sb_data;
                        pf_addr_q  <= miss_addr + ONE;
                        pf_pend_q  <= 1'b1;
                    end else if (miss_fire) begin
                        dem_addr_q <= miss_addr;
                        pf_pend_q  <= 1'b0;
                        state_q    <= ST_DEM_REQ;
                    end
                end
                ST_DEM_REQ: begin
                    if (req_fire) begin
                        state_q <= ST_DEM_WAIT;
                    end
                end
                ST_DEM_WAIT: begin
                    if (resp_valid) begin
                        fill_valid <= 1'b1;
                        fill_addr  <= dem_addr_q;
                        fill_data  <= resp_data;
                        pf_addr_q  <= dem_addr_q + ONE;
                        pf_pend_q  <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/isb_prefetch.sv
// Top of the instruction stream buffer prefetcher: joins the controller
// to the one-entry line buffer. Assumes line-granular addresses and a
// cache that holds miss_valid and miss_addr until miss_ready.
module isb_prefetch #(
    parameter int ADDR_W = 12,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_ready,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [LINE_W-1:0] fill_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_resp_valid,
    input  logic [LINE_W-1:0] mem_resp_data
);
    logic              sb_hit;
    logic              sb_valid;
    logic [LINE_W-1:0] sb_data;
    logic              sb_wr_en;
    logic [ADDR_W-1:0] sb_wr_addr;
    logic [LINE_W-1:0] sb_wr_data;
    logic              sb_clear;

    isb_line_buf #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sb_wr_en),
        .wr_addr   (sb_wr_addr),
        .wr_data   (sb_wr_data),
        .clear     (sb_clear),
        .look_addr (miss_addr),
        .hit       (sb_hit),
        .valid_o   (sb_valid),
        .data_o    (sb_data)
    );

    isb_ctrl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .miss_addr  (miss_addr),
        .miss_ready (miss_ready),
        .sb_hit     (sb_hit),
        .sb_data    (sb_data),
        .sb_wr_en   (sb_wr_en),
        .sb_wr_addr (sb_wr_addr),
        .sb_wr_data (sb_wr_data),
        .sb_clear   (sb_clear),
        .req_valid  (mem_req_valid),
        .req_addr   (mem_req_addr),
        .req_ready  (mem_req_ready),
        .resp_valid (mem_resp_valid),
        .resp_data  (mem_resp_data),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data)
    );
endmodule

// File: rtl/isb_prefetch_chk.sv
// Protocol and sequencing checks for isb_prefetch, attached by bind.
// Tracks outstanding reads and the last demand address on its own.
module isb_prefetch_chk #(
    parameter int ADDR_W = 12,
    parameter int LINE_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              miss_ready,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_ready,
    input logic              mem_resp_valid,
    input logic              sb_hit,
    input logic              sb_valid
);
    logic              out_q;
    logic [ADDR_W-1:0] last_miss_q;

    // Independent count of reads accepted but not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q       <= 1'b0;
            last_miss_q <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready) out_q <= 1'b1;
            else if (mem_resp_valid)            out_q <= 1'b0;
            if (miss_valid && miss_ready)       last_miss_q <= miss_addr;
        end
    end

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !out_q);

    // R4
    hit_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && sb_hit) |=> (fill_valid && fill_addr == $past(miss_addr)));

    // R6
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && !sb_hit) |=> !sb_valid);

    // R10
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && !sb_hit) |=> !miss_ready);

    // R2
    dem_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !miss_ready) |-> (mem_req_addr == last_miss_q));
endmodule

bind isb_prefetch isb_prefetch_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .miss_addr      (miss_addr),
    .miss_ready     (miss_ready),
    .fill_valid     (fill_valid),
    .fill_addr      (fill_addr),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .mem_req_ready  (mem_req_ready),
    .mem_resp_valid (mem_resp_valid),
    .sb_hit         (sb_hit),
    .sb_valid       (sb_valid)
);

// File: tb/sim_isb_prefetch.sv
`timescale 1ns/1ps
module sim_isb_prefetch;
    localparam int AW = 12;
    localparam int LW = 64;
    localparam int AM = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          miss_ready;
    logic          fill_valid;
    logic [AW-1:0] fill_addr;
    logic [LW-1:0] fill_data;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b1;
    logic          mem_resp_valid = 1'b0;
    logic [LW-1:0] mem_resp_data = '0;

    always #2.5 clk = ~clk;

    isb_prefetch #(.ADDR_W(AW), .LINE_W(LW)) u0 (.*);

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    // reference model state
    int m_sb_v = 0, m_sb_a = 0;
    int m_req = 0, m_req_a = 0;           // 0 none, 1 prefetch, 2 demand
    string m_req_tag = "R1";
    int m_busy = 0, m_busy_kind = 0, m_drop = 0;
    int m_dem = 0, m_dem_a = 0;
    string m_dem_tag = "R2";
    int exp_fill_cyc = -1, exp_fill_a = 0;
    string exp_fill_tag = "R2";
    int mem_pend = 0, mem_due = 0, mem_a = 0, lat = 3;
    bit rdy_mode = 1'b1;
    bit want_miss = 1'b0;
    int want_a = 0;
    int fills_seen = 0;

    function automatic logic [LW-1:0] line_data(int a);
        logic [15:0] s;
        s = a[15:0];
        return {16'h5A00 ^ s, s * 16'd7, ~s, s + 16'h1234};
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic step();
        bit acc, hit, fire, exp_rv;
        int resp_a;
        string tag;
        @(negedge clk);
        cyc++;
        // compare outputs with the model
        chk(fill_valid == (exp_fill_cyc == cyc), exp_fill_tag, "fill_valid",
            64'(fill_valid), 64'(exp_fill_cyc == cyc));
        if (fill_valid && exp_fill_cyc == cyc) begin
            chk(fill_addr == AW'(exp_fill_a), exp_fill_tag, "fill_addr",
                64'(fill_addr), 64'(exp_fill_a));
            chk(fill_data == line_data(exp_fill_a), exp_fill_tag, "fill_data",
                fill_data, line_data(exp_fill_a));
            fills_seen++;
        end
        exp_rv = (m_req != 0) && (m_busy == 0);
        chk(mem_req_valid == exp_rv, (m_busy != 0) ? "R9" : m_req_tag, "mem_req_valid",
            64'(mem_req_valid), 64'(exp_rv));
        if (mem_req_valid && exp_rv)
            chk(mem_req_addr == AW'(m_req_a), m_req_tag, "mem_req_addr",
                64'(mem_req_addr), 64'(m_req_a));
        chk(miss_ready == (m_dem == 0), "R10", "miss_ready", 64'(miss_ready), 64'(m_dem == 0));
        // drive inputs for the coming edge
        resp_a = mem_a;
        if (mem_pend != 0 && mem_due == cyc) begin
            mem_resp_valid = 1'b1;
            mem_resp_data  = line_data(mem_a);
            mem_pend       = 0;
        end else begin
            mem_resp_valid = 1'b0;
        end
        mem_req_ready = rdy_mode;
        miss_valid    = want_miss;
        miss_addr     = AW'(want_a);
        // predict the coming edge
        acc  = miss_valid && miss_ready;
        hit  = acc && (m_sb_v != 0) && (m_sb_a == want_a);
        fire = mem_req_valid && mem_req_ready;
        if (mem_resp_valid) begin
            m_busy = 0;
            if (m_busy_kind == 1) begin
                if (m_drop == 0) begin m_sb_v = 1; m_sb_a = resp_a; end
                m_drop = 0;
            end else begin
                exp_fill_cyc = cyc + 1; exp_fill_a = m_dem_a; exp_fill_tag = m_dem_tag;
                m_dem = 0;
                m_req = 1; m_req_a = (m_dem_a + 1) & AM; m_req_tag = "R3";
            end
        end
        if (fire) begin
            mem_pend = 1; mem_a = int'(mem_req_addr); mem_due = cyc + lat;
            m_busy = 1; m_busy_kind = m_req; m_req = 0;
        end
        if (acc) begin
            want_miss = 1'b0;
            if (hit) begin
                exp_fill_cyc = cyc + 1; exp_fill_a = want_a; exp_fill_tag = "R4";
                m_sb_v = 0;
                m_req = 1; m_req_a = (want_a + 1) & AM; m_req_tag = "R5";
            end else begin
                if (m_sb_v != 0) tag = "R6";
                else if (m_req == 1) tag = "R7";
                else if (m_busy != 0 && m_busy_kind == 1) tag = "R8";
                else tag = "R2";
                if (m_busy != 0 && m_busy_kind == 1) m_drop = 1;
                m_sb_v = 0;
                m_req = 2; m_req_a = want_a; m_req_tag = tag;
                m_dem = 1; m_dem_a = want_a; m_dem_tag = tag;
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_miss(int a);
        int start;
        start = fills_seen;
        want_miss = 1'b1;
        want_a = a;
        for (int i = 0; i < 300 && fills_seen == start; i++) step();
        chk(fills_seen > start, "R2", "miss completed", 64'(fills_seen - start), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        chk(fill_valid == 1'b0, "R1", "fill_valid in reset", 64'(fill_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
        chk(miss_ready == 1'b1, "R1", "miss_ready in reset", 64'(miss_ready), 64'd1);
        rst_n = 1'b1;
        idle(3);
        // R1/R2: empty buffer, first miss goes to memory
        do_miss(12'h100);
        idle(8);
        // R4/R5: sequential walk through the buffer
        for (int a = 12'h101; a <= 12'h105; a++) begin
            do_miss(a);
            idle(8);
        end
        // R6: unrelated miss discards buffered line, old line then refetched
        do_miss(12'h200);
        idle(8);
        do_miss(12'h106);
        idle(8);
        // R7: prefetch stalled at the port is replaced by a demand
        want_miss = 1'b1; want_a = 12'h300;
        for (int i = 0; i < 50 && !(m_busy != 0 && m_busy_kind == 2); i++) step();
        rdy_mode = 1'b0;
        for (int i = 0; i < 50 && want_miss; i++) step();
        idle(lat + 2);
        want_miss = 1'b1; want_a = 12'h350;
        idle(3);
        rdy_mode = 1'b1;
        do_miss(12'h350);
        idle(8);
        // R8: prefetch in flight when a demand arrives
        lat = 6;
        do_miss(12'h400);
        idle(2);
        do_miss(12'h500);
        idle(12);
        do_miss(12'h401);
        idle(12);
        // R3: wrap of the prefetch address
        lat = 1;
        do_miss(12'hFFF);
        idle(6);
        do_miss(12'h000);
        idle(6);
        lat = 2;
        do_miss(12'h001);
        idle(6);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule